// File: doc/BRIEF.md
# Operand Address Former

This block turns an addressing-mode code and the raw operands of an instruction into a 24-bit operand address. The operands are an address register, an index value, a displacement or short offset, the updated program counter and an absolute word. For the auto-increment and auto-decrement modes, it also produces the new address-register value and a write-back strobe. A decoder drives the inputs with a one-cycle request pulse. The result is registered and appears on the next clock edge together with a valid pulse. The register file takes the write-back value.

All address arithmetic is done at 32 bits, and only the low 24 bits are presented as the address. The write-back value keeps all 32 bits. The block flags any word or long access whose address is odd.

Mode codes on `mode`:

| Code | Mode |
|------|------|
| 0 | register indirect |
| 1 | post-increment |
| 2 | pre-decrement |
| 3 | register plus 16-bit displacement |
| 4 | register plus index plus 8-bit offset |
| 5 | PC plus 16-bit displacement |
| 6 | PC plus index plus 8-bit offset |
| 7 | absolute short |
| 8 | absolute long |
| 9 to 15 | unused |

Size codes on `size`:

| Code | Size |
|------|------|
| 0 | byte |
| 1 | word |
| 2 | long |
| 3 | treated as long |

Top module: `ea_gen`

## Requirements
- R1: With mode 0, the address is the address register value.
- R2: With mode 3, the address is the address register plus `disp` sign-extended from bit 15.
- R3: With mode 4, the address is the address register plus the full 32-bit `idx` plus `disp[7:0]` sign-extended from bit 7.
- R4: With mode 1, the address is the register value, and the write-back value is the register plus 1, 2 or 4 for size 0, 1 or 2 (4 for size 3).
- R5: With mode 2, the register is first reduced by 1, 2 or 4 by size, and the reduced value is both the address and the write-back value.
- R6: With mode 5 the address is `pc` plus sign-extended `disp`; with mode 6 it is `pc` plus `idx` plus sign-extended `disp[7:0]`.
- R7: With mode 7, the address is `absw[15:0]` sign-extended from bit 15, so it lies in the lowest or highest 32K bytes; with mode 8, the address is `absw`.
- R8: Only bits 23:0 of the 32-bit sum are output on `ea`; `wb_data` carries all 32 bits.
- R9: `wb_en` is 1 only on the result of a mode 1 or mode 2 request.
- R10: `mis_align` is 1 when a word or long access (size other than 0) has an odd address; byte accesses never raise it.
- R11: Results and a one-cycle `vld` pulse appear on the clock edge that samples `req`; after reset `vld`, `wb_en`, `mis_align` and `ea` are 0.
- R12: Unused mode codes 9 to 15 give `ea` 0, no write-back and no alignment flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req | input | 1 | request; operands sampled at this edge |
| mode | input | 4 | addressing mode code |
| size | input | 2 | operand size code |
| areg | input | 32 | address register contents |
| idx | input | 32 | index register contents |
| disp | input | 16 | displacement; low byte is the short offset |
| pc | input | 32 | updated program counter |
| absw | input | 32 | absolute address word (short uses bits 15:0) |
| vld | output | 1 | result valid pulse |
| ea | output | 24 | effective address |
| wb_en | output | 1 | address register write-back strobe |
| wb_data | output | 32 | new address register value |
| mis_align | output | 1 | odd address on word or long access |

## Verification
Every result is due exactly one clock edge after the request is sampled. `req` and the operands are driven at a falling edge. The rising edge then registers the result, and the bench reads the outputs at the next falling edge, half a period later. The bench drops `req` at that same falling edge. It checks one further falling edge later that `vld` and `wb_en` have returned to 0, which confirms that a result is a single-cycle pulse.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW   = 24,
  parameter int DW   = 32,
  parameter int DSPW = 16,
  parameter int OFSW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [3:0]    mode,
  input  logic [1:0]    size,
  input  logic [DW-1:0] areg,
  input  logic [DW-1:0] idx,
  input  logic [DSPW-1:0] disp,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] absw,
  output logic          vld,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [DW-1:0] wb_data,
  output logic          mis_align
);
  localparam logic [3:0] M_IND  = 4'd0;
  localparam logic [3:0] M_INC  = 4'd1;
  localparam logic [3:0] M_DEC  = 4'd2;
  localparam logic [3:0] M_ADSP = 4'd3;
  localparam logic [3:0] M_AIDX = 4'd4;
  localparam logic [3:0] M_PDSP = 4'd5;
  localparam logic [3:0] M_PIDX = 4'd6;
  localparam logic [3:0] M_ABSS = 4'd7;
  localparam logic [3:0] M_ABSL = 4'd8;
  localparam int SHW = 16;

  logic [DW-1:0] step, disp_x, ofs_x, abs_x, sum, wb_c;
  logic          wen_c, known;

  assign step   = (size == 2'd0) ? DW'(1) : (size == 2'd1) ? DW'(2) : DW'(4);
  assign disp_x = {{(DW-DSPW){disp[DSPW-1]}}, disp};
  assign ofs_x  = {{(DW-OFSW){disp[OFSW-1]}}, disp[OFSW-1:0]};
  assign abs_x  = {{(DW-SHW){absw[SHW-1]}}, absw[SHW-1:0]};

  always_comb begin
    sum   = '0;
    wb_c  = areg;
    wen_c = 1'b0;
    known = 1'b1;
    case (mode)
      M_IND:  sum = areg;
      M_INC:  begin sum = areg; wb_c = areg + step; wen_c = 1'b1; end
      M_DEC:  begin sum = areg - step; wb_c = areg - step; wen_c = 1'b1; end
      M_ADSP: sum = areg + disp_x;
      M_AIDX: sum = areg + idx + ofs_x;
      M_PDSP: sum = pc + disp_x;
      M_PIDX: sum = pc + idx + ofs_x;
      M_ABSS: sum = abs_x;
      M_ABSL: sum = absw;
      default: known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= 1'b0;
      ea        <= '0;
      wb_en     <= 1'b0;
      wb_data   <= '0;
      mis_align <= 1'b0;
    end else begin
      vld       <= req;
      wb_en     <= req && wen_c;
      mis_align <= req && known && sum[0] && (size != 2'd0);
      if (req) begin
        ea      <= sum[AW-1:0];
        wb_data <= wb_c;
      end
    end
  end

  // R11: valid pulse follows the request one edge later
  p_vld_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> vld);
  p_vld_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !vld && !wb_en);
  // R9: write-back only for auto modes
  p_wb_auto_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> vld && ($past(mode) == M_INC || $past(mode) == M_DEC));
  // R4: post-increment keeps the old value as address
  p_postinc_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && $past(mode) == M_INC) |-> ea == $past(areg[AW-1:0]));
  // R5: pre-decrement address equals the written-back value
  p_predec_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && $past(mode) == M_DEC) |-> ea == wb_data[AW-1:0]);
  // R7: short absolute upper bits replicate bit 15
  p_abs_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && $past(mode) == M_ABSS) |->
      ($countones(ea[AW-1:SHW-1]) == 0 || $countones(ea[AW-1:SHW-1]) == AW-SHW+1));
  // R10: flag only on odd non-byte addresses
  p_misalign_odd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mis_align |-> vld && ea[0] && $past(size) != 2'd0);
  // R12: unused modes give zero address and no write-back
  p_unused_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && $past(mode) > M_ABSL) |-> ea == '0 && !wb_en && !mis_align);
endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  size = '0;
  logic [31:0] areg = '0, idx = '0, pc = '0, absw = '0;
  logic [15:0] disp = '0;
  logic        vld, wb_en, mis_align;
  logic [23:0] ea;
  logic [31:0] wb_data;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ea_gen u_ea_gen (.clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .size(size),
    .areg(areg), .idx(idx), .disp(disp), .pc(pc), .absw(absw),
    .vld(vld), .ea(ea), .wb_en(wb_en), .wb_data(wb_data), .mis_align(mis_align));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [3:0] m, input logic [1:0] s, input logic [31:0] a,
                      input logic [31:0] x, input logic [15:0] d, input logic [31:0] p,
                      input logic [31:0] ab);
    @(negedge clk);
    mode = m; size = s; areg = a; idx = x; disp = d; pc = p; absw = ab; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [23:0] e_ea, input logic e_wb,
                            input logic [31:0] e_wbd, input logic e_mis);
    chk({tag, " vld"}, {31'd0, vld}, 32'd1);
    chk({tag, " ea"}, {8'd0, ea}, {8'd0, e_ea});
    chk({tag, " wb_en"}, {31'd0, wb_en}, {31'd0, e_wb});
    if (e_wb) chk({tag, " wb_data"}, wb_data, e_wbd);
    chk({tag, " mis_align"}, {31'd0, mis_align}, {31'd0, e_mis});
  endtask

  task automatic t_reset;
    chk("R11 reset vld", {31'd0, vld}, 32'd0);
    chk("R11 reset ea", {8'd0, ea}, 32'd0);
    chk("R11 reset wb_en", {31'd0, wb_en}, 32'd0);
    chk("R11 reset mis_align", {31'd0, mis_align}, 32'd0);
  endtask

  task automatic t_indirect;
    fire(4'd0, 2'd1, 32'h0034_5678, 0, 0, 0, 0);
    expect_out("R1 indirect", 24'h345678, 1'b0, 0, 1'b0);
    fire(4'd0, 2'd1, 32'hFF00_0010, 0, 0, 0, 0);
    expect_out("R8 truncate", 24'h000010, 1'b0, 0, 1'b0);
  endtask

  task automatic t_disp;
    fire(4'd3, 2'd1, 32'h0000_1000, 0, 16'hFFF0, 0, 0);
    expect_out("R2 negative disp", 24'h000FF0, 1'b0, 0, 1'b0);
    fire(4'd3, 2'd2, 32'h0000_1000, 0, 16'h7FFE, 0, 0);
    expect_out("R2 positive disp", 24'h008FFE, 1'b0, 0, 1'b0);
  endtask

  task automatic t_index;
    fire(4'd4, 2'd1, 32'h0000_2000, 32'hFFFF_FFFC, 16'h1280, 0, 0);
    expect_out("R3 index offset", 24'h001F7C, 1'b0, 0, 1'b0);
  endtask

  task automatic t_postinc;
    fire(4'd1, 2'd2, 32'h0000_0100, 0, 0, 0, 0);
    expect_out("R4 postinc long", 24'h000100, 1'b1, 32'h0000_0104, 1'b0);
    @(negedge clk);
    chk("R11 vld pulse ends", {31'd0, vld}, 32'd0);
    chk("R9 wb_en pulse ends", {31'd0, wb_en}, 32'd0);
    fire(4'd1, 2'd0, 32'h0000_0101, 0, 0, 0, 0);
    expect_out("R4 postinc byte", 24'h000101, 1'b1, 32'h0000_0102, 1'b0);
    fire(4'd1, 2'd3, 32'h0000_0200, 0, 0, 0, 0);
    expect_out("R4 postinc size3", 24'h000200, 1'b1, 32'h0000_0204, 1'b0);
  endtask

  task automatic t_predec;
    fire(4'd2, 2'd1, 32'h0000_0200, 0, 0, 0, 0);
    expect_out("R5 predec word", 24'h0001FE, 1'b1, 32'h0000_01FE, 1'b0);
    fire(4'd2, 2'd2, 32'h0000_0000, 0, 0, 0, 0);
    expect_out("R5 R8 predec wrap", 24'hFFFFFC, 1'b1, 32'hFFFF_FFFC, 1'b0);
  endtask

  task automatic t_pcrel;
    fire(4'd5, 2'd1, 32'h1111_1111, 0, 16'h8000, 32'h0000_4000, 0);
    expect_out("R6 pc disp", 24'hFFC000, 1'b0, 0, 1'b0);
    fire(4'd6, 2'd0, 32'h1111_1111, 32'h0000_0010, 16'hAA7F, 32'h0000_1000, 0);
    expect_out("R6 pc index", 24'h00108F, 1'b0, 0, 1'b0);
  endtask

  task automatic t_absolute;
    fire(4'd7, 2'd1, 0, 0, 0, 0, 32'h0000_8000);
    expect_out("R7 abs short high", 24'hFF8000, 1'b0, 0, 1'b0);
    fire(4'd7, 2'd1, 0, 0, 0, 0, 32'hFFFF_7FFE);
    expect_out("R7 abs short low", 24'h007FFE, 1'b0, 0, 1'b0);
    fire(4'd8, 2'd2, 0, 0, 0, 0, 32'hAB12_3456);
    expect_out("R7 R8 abs long", 24'h123456, 1'b0, 0, 1'b0);
  endtask

  task automatic t_align;
    fire(4'd0, 2'd1, 32'h0000_1001, 0, 0, 0, 0);
    expect_out("R10 odd word", 24'h001001, 1'b0, 0, 1'b1);
    fire(4'd3, 2'd2, 32'h0000_1000, 0, 16'h0003, 0, 0);
    expect_out("R10 odd long", 24'h001003, 1'b0, 0, 1'b1);
    fire(4'd0, 2'd0, 32'h0000_1001, 0, 0, 0, 0);
    expect_out("R10 odd byte", 24'h001001, 1'b0, 0, 1'b0);
  endtask

  task automatic t_unused;
    fire(4'd9, 2'd1, 32'h0000_1235, 0, 0, 0, 0);
    expect_out("R12 unused 9", 24'h000000, 1'b0, 0, 1'b0);
    fire(4'd15, 2'd2, 32'h0000_0777, 0, 0, 0, 32'h0000_0777);
    expect_out("R12 R9 unused 15", 24'h000000, 1'b0, 0, 1'b0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_indirect();
    t_disp();
    t_index();
    t_postinc();
    t_predec();
    t_pcrel();
    t_absolute();
    t_align();
    t_unused();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule